// File: doc/BRIEF.md
# ADC Offset Calibration Sequencer

This block is a hardware sequencer that measures the offset of an analog-to-digital converter and turns it into a calibration code. When a request arrives, it latches the requested attenuation and calibration source. It switches on the converter reference and sets up single-shot mode on the fixed internal calibration channel (15). It then closes the selected source switch, which is either ground or the reference. After that it steps through a fixed number of conversions, one at a time.

Each conversion runs the same handshake. The sequencer writes an initial code of zero, split into a high byte and a low byte. It raises the start line and waits for the done flag. It takes the low 12 bits of the data and pulses the write-one-to-clear strobe of the done flag. Only then does it drop start.

For every sample it keeps a running sum, the largest value and the smallest value. After the last sample it removes the largest and the smallest from the sum and divides the rest by the sample count minus two, using a bit-serial divider. It then opens the source switch and presents the 12-bit result with a one-cycle valid pulse.

The states of the machine are, in order:
- IDLE waits for a request. A request moves it to SETUP.
- SETUP enables the reference and single-shot mode and clears the statistics. It moves to CONNECT.
- CONNECT closes the source switch. It moves to INIT.
- INIT writes the zero initial code. It moves to START.
- START raises start. It moves to WAIT.
- WAIT holds start until done is seen, then moves to CLEAR.
- CLEAR pulses the done-clear strobe with start still high. It moves to RELEASE.
- RELEASE drops start. It goes back to INIT for the next sample, or to DIVIDE after the last one.
- DIVIDE waits for the quotient. It moves to DISCONNECT.
- DISCONNECT opens the switch. It moves to FINISH.
- FINISH pulses valid. It returns to IDLE.

Top module: `adc_offset_cal`

## Requirements
- R1: After reset, busy, result_valid, conv_start, conv_done_clr, init_code_wr, conv_ref_en, conv_oneshot_en, cal_gnd_conn and cal_ref_conn are all 0.
- R2: A req_start pulse seen in IDLE raises busy in the next cycle. On every rising edge of conv_start, conv_ref_en and conv_oneshot_en are 1, conv_chan is 15, and conv_atten equals the attenuation latched with the request.
- R3: With req_src = 0, only cal_gnd_conn is asserted; with req_src = 1, only cal_ref_conn is asserted. The selected switch is closed before the first conv_start and stays closed on every conversion of the run.
- R4: Every run performs exactly 32 conversions, counted as rising edges of conv_start.
- R5: Each conversion is preceded by an init_code_wr pulse with both code bytes equal to zero. conv_done_clr pulses for one cycle only after conv_done was seen while conv_start is high, and conv_start falls in the cycle after that pulse.
- R6: Only bits [11:0] of conv_data contribute to the result; bits [15:12] are ignored.
- R7: result equals floor((sum of samples - largest sample - smallest sample) / 30). When the extreme value occurs more than once, only one copy is removed.
- R8: result_valid is a single-cycle pulse. Both source switches are open while it is high, busy is still 1 in that cycle, and busy is 0 in the next cycle.
- R9: A req_start that arrives while busy is ignored. The run keeps its latched attenuation, and no second run starts after it finishes.
- R10: conv_done asserted while the sequencer is not waiting for a conversion (in IDLE, or after the last sample) has no effect on busy, the conversion count or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request a calibration run (accepted only in IDLE) |
| req_atten | input | 3 | Attenuation for the run |
| req_src | input | 1 | Calibration source: 0 ground, 1 reference |
| conv_ref_en | output | 1 | Converter reference enable |
| conv_oneshot_en | output | 1 | Single-shot conversion mode enable |
| conv_chan | output | 4 | Conversion channel (fixed calibration channel) |
| conv_atten | output | 3 | Conversion attenuation |
| conv_start | output | 1 | Conversion start level |
| conv_done | input | 1 | Conversion done flag from the converter |
| conv_data | input | 16 | Raw conversion data |
| conv_done_clr | output | 1 | Write-one-to-clear strobe for the done flag |
| init_code_wr | output | 1 | Initial-code write strobe |
| init_code_hi | output | 8 | Initial code, high byte |
| init_code_lo | output | 8 | Initial code, low byte |
| cal_gnd_conn | output | 1 | Connect ground to the converter input |
| cal_ref_conn | output | 1 | Connect reference to the converter input |
| busy | output | 1 | Run in progress |
| result | output | 12 | Trimmed-mean calibration code |
| result_valid | output | 1 | One-cycle result strobe |

## Verification
The hardest condition to reach is a done flag that arrives when the sequencer is not waiting for one. In a normal run, the converter model only raises done while start is high, so the stimulus has to force it. The bench ORs an injected done onto the converter output in two places: in IDLE, and in the cycles after the thirty-second clear while the divider is still running. It then checks that the result and the conversion count are unchanged. A second request is also injected partway through a run, carrying a different attenuation. Sample sets with repeated extremes, a saturated run, and garbage in the upper data bits cover the trimming and masking rules.

// File: rtl/adccal_pkg.sv
package adccal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CONNECT,
        ST_INIT,
        ST_START,
        ST_WAIT,
        ST_CLEAR,
        ST_RELEASE,
        ST_DIVIDE,
        ST_DISCONNECT,
        ST_FINISH
    } cal_state_e;

    typedef enum logic {
        SRC_GROUND    = 1'b0,
        SRC_REFERENCE = 1'b1
    } cal_src_e;

endpackage

// File: rtl/adccal_stats.sv
module adccal_stats #(
    parameter int DATA_W = 12,
    parameter int SUM_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] sample,
    output logic [SUM_W-1:0]  sum_q,
    output logic [DATA_W-1:0] max_q,
    output logic [DATA_W-1:0] min_q
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum_q <= '0;
            max_q <= '0;
            min_q <= '1;
        end else if (load) begin
            sum_q <= sum_q + SUM_W'(sample);
            if (sample > max_q) max_q <= sample;
            if (sample < min_q) min_q <= sample;
        end
    end

    // R7: after any sample the extremes are ordered
    a_r7_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        load && !clear |=> (min_q <= max_q));

    // R7: accumulation never wraps
    a_r7_sum_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        load && !clear |=> (sum_q >= $past(sum_q)));

endmodule

// File: rtl/adccal_div.sv
module adccal_div #(
    parameter int NUM_W   = 17,
    parameter int DIVISOR = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] dividend,
    output logic             done,
    output logic [NUM_W-1:0] quotient
);

    localparam int DEN_W = $clog2(DIVISOR + 1);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [DEN_W:0] DEN_V = (DEN_W + 1)'(DIVISOR);

    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             running_q;
    logic [DEN_W:0]   shifted;
    logic             fits;

    assign shifted  = {rem_q, num_q[NUM_W-1]};
    assign fits     = (shifted >= DEN_V);
    assign quotient = num_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q     <= '0;
            rem_q     <= '0;
            cnt_q     <= '0;
            running_q <= 1'b0;
            done      <= 1'b0;
        end else if (go) begin
            num_q     <= dividend;
            rem_q     <= '0;
            cnt_q     <= CNT_W'(NUM_W);
            running_q <= 1'b1;
            done      <= 1'b0;
        end else if (running_q) begin
            if (fits) begin
                rem_q <= DEN_W'(shifted - DEN_V);
                num_q <= {num_q[NUM_W-2:0], 1'b1};
            end else begin
                rem_q <= shifted[DEN_W-1:0];
                num_q <= {num_q[NUM_W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                running_q <= 1'b0;
                done      <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R7: the divider reports completion once per request
    a_r7_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the partial remainder stays below the divisor
    a_r7_rem_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |=> ((DEN_W + 1)'(rem_q) < DEN_V));

endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal
    import adccal_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int RAW_W       = 16,
    parameter int ATTEN_W     = 3,
    parameter int CHAN_W      = 4,
    parameter int CAL_CHAN    = 15,
    parameter int NUM_SAMPLES = 32,
    parameter int INIT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_start,
    input  logic [ATTEN_W-1:0] req_atten,
    input  logic               req_src,
    output logic               conv_ref_en,
    output logic               conv_oneshot_en,
    output logic [CHAN_W-1:0]  conv_chan,
    output logic [ATTEN_W-1:0] conv_atten,
    output logic               conv_start,
    input  logic               conv_done,
    input  logic [RAW_W-1:0]   conv_data,
    output logic               conv_done_clr,
    output logic               init_code_wr,
    output logic [INIT_W/2-1:0] init_code_hi,
    output logic [INIT_W/2-1:0] init_code_lo,
    output logic               cal_gnd_conn,
    output logic               cal_ref_conn,
    output logic               busy,
    output logic [DATA_W-1:0]  result,
    output logic               result_valid
);

    localparam int SUM_W    = DATA_W + $clog2(NUM_SAMPLES);
    localparam int CNT_W    = $clog2(NUM_SAMPLES + 1);
    localparam int TRIM_DIV = NUM_SAMPLES - 2;
    localparam int BYTE_W   = INIT_W / 2;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SAMPLES - 1);
    localparam logic [INIT_W-1:0] INIT_CODE = '0;

    cal_state_e         state_q, state_d;
    logic [ATTEN_W-1:0] atten_q;
    cal_src_e           src_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DATA_W-1:0]  result_q;

    logic [SUM_W-1:0]   sum_w;
    logic [DATA_W-1:0]  max_w, min_w;
    logic [SUM_W-1:0]   trimmed;
    logic [SUM_W-1:0]   quot_w;
    logic               div_done;
    logic               stats_clear, stats_load, div_go, last_sample;
    logic               switch_on;

    assign last_sample = (cnt_q == LAST_IDX);
    assign stats_clear = (state_q == ST_SETUP);
    assign stats_load  = (state_q == ST_WAIT) && conv_done;
    assign div_go      = (state_q == ST_RELEASE) && last_sample;
    assign trimmed     = sum_w - SUM_W'(max_w) - SUM_W'(min_w);

    adccal_stats #(
        .DATA_W (DATA_W),
        .SUM_W  (SUM_W)
    ) u_stats (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (stats_clear),
        .load   (stats_load),
        .sample (conv_data[DATA_W-1:0]),
        .sum_q  (sum_w),
        .max_q  (max_w),
        .min_q  (min_w)
    );

    adccal_div #(
        .NUM_W   (SUM_W),
        .DIVISOR (TRIM_DIV)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (trimmed),
        .done     (div_done),
        .quotient (quot_w)
    );

    // state register and run context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            atten_q  <= '0;
            src_q    <= SRC_GROUND;
            cnt_q    <= '0;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_start) begin
                atten_q <= req_atten;
                src_q   <= cal_src_e'(req_src);
            end
            if (state_q == ST_SETUP) begin
                cnt_q <= '0;
            end else if (state_q == ST_RELEASE && !last_sample) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_DIVIDE && div_done) begin
                result_q <= quot_w[DATA_W-1:0];
            end
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_start) state_d = ST_SETUP;
            ST_SETUP:      state_d = ST_CONNECT;
            ST_CONNECT:    state_d = ST_INIT;
            ST_INIT:       state_d = ST_START;
            ST_START:      state_d = ST_WAIT;
            ST_WAIT:       if (conv_done) state_d = ST_CLEAR;
            ST_CLEAR:      state_d = ST_RELEASE;
            ST_RELEASE:    state_d = last_sample ? ST_DIVIDE : ST_INIT;
            ST_DIVIDE:     if (div_done) state_d = ST_DISCONNECT;
            ST_DISCONNECT: state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        conv_ref_en     = 1'b0;
        conv_oneshot_en = 1'b0;
        conv_start      = 1'b0;
        conv_done_clr   = 1'b0;
        init_code_wr    = 1'b0;
        switch_on       = 1'b0;
        busy            = 1'b1;
        result_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE:       busy = 1'b0;
            ST_SETUP: begin
                conv_ref_en     = 1'b1;
                conv_oneshot_en = 1'b1;
            end
            ST_CONNECT, ST_RELEASE, ST_DIVIDE: begin
                conv_ref_en     = 1'b1;
                conv_oneshot_en = 1'b1;
                switch_on       = 1'b1;
            end
            ST_INIT: begin
                conv_ref_en     = 1'b1;
                conv_oneshot_en = 1'b1;
                switch_on       = 1'b1;
                init_code_wr    = 1'b1;
            end
            ST_START, ST_WAIT: begin
                conv_ref_en     = 1'b1;
                conv_oneshot_en = 1'b1;
                switch_on       = 1'b1;
                conv_start      = 1'b1;
            end
            ST_CLEAR: begin
                conv_ref_en     = 1'b1;
                conv_oneshot_en = 1'b1;
                switch_on       = 1'b1;
                conv_start      = 1'b1;
                conv_done_clr   = 1'b1;
            end
            ST_DISCONNECT: begin
                conv_ref_en     = 1'b1;
                conv_oneshot_en = 1'b1;
            end
            ST_FINISH:     result_valid = 1'b1;
            default:       busy = 1'b0;
        endcase
    end

    assign conv_chan    = CHAN_W'(CAL_CHAN);
    assign conv_atten   = atten_q;
    assign init_code_hi = INIT_CODE[INIT_W-1:BYTE_W];
    assign init_code_lo = INIT_CODE[BYTE_W-1:0];
    assign cal_gnd_conn = switch_on && (src_q == SRC_GROUND);
    assign cal_ref_conn = switch_on && (src_q == SRC_REFERENCE);
    assign result       = result_q;

    // R2: conversions only run with the converter configured
    a_r2_configured: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_ref_en && conv_oneshot_en));

    // R3: never both switches closed
    a_r3_one_switch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cal_gnd_conn, cal_ref_conn}));

    // R3: a source is connected whenever a conversion is active
    a_r3_connected: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (cal_gnd_conn || cal_ref_conn));

    // R4: sample index never passes the last sample
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

    // R5: start rises only right after the initial-code write
    a_r5_init_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_start) |-> $past(init_code_wr));

    // R5: clear strobe follows an observed done
    a_r5_clear_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_clr |-> $past(conv_done));

    // R5: start falls only after the clear strobe
    a_r5_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_start) |-> $past(conv_done_clr));

    // R8: single-cycle valid, busy drops after it
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> (!result_valid && !busy));

    // R8: source disconnected when the result is presented
    a_r8_disconnected: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (!cal_gnd_conn && !cal_ref_conn));

    // R9: a request during a run does not restart setup
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_start |=> (state_q != ST_SETUP));

endmodule

// File: tb/tb_adc_offset_cal.sv
module tb_adc_offset_cal;

    localparam int PERIOD = 10;
    localparam int NS     = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [2:0]  req_atten = '0;
    logic        req_src = 1'b0;
    logic        conv_ref_en, conv_oneshot_en, conv_start, conv_done_clr;
    logic [3:0]  conv_chan;
    logic [2:0]  conv_atten;
    logic        conv_done;
    logic [15:0] conv_data;
    logic        init_code_wr;
    logic [7:0]  init_code_hi, init_code_lo;
    logic        cal_gnd_conn, cal_ref_conn, busy, result_valid;
    logic [11:0] result;

    always #(PERIOD/2) clk = ~clk;

    adc_offset_cal dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_atten(req_atten),
        .req_src(req_src), .conv_ref_en(conv_ref_en), .conv_oneshot_en(conv_oneshot_en),
        .conv_chan(conv_chan), .conv_atten(conv_atten), .conv_start(conv_start),
        .conv_done(conv_done), .conv_data(conv_data), .conv_done_clr(conv_done_clr),
        .init_code_wr(init_code_wr), .init_code_hi(init_code_hi), .init_code_lo(init_code_lo),
        .cal_gnd_conn(cal_gnd_conn), .cal_ref_conn(cal_ref_conn), .busy(busy),
        .result(result), .result_valid(result_valid)
    );

    // converter model
    logic [11:0] smp [NS];
    logic [3:0]  garb [NS];
    logic        m_done;
    logic [15:0] m_raw;
    logic [7:0]  m_idx;
    logic [3:0]  m_lat;
    logic        spur = 1'b0;

    assign conv_done = m_done | spur;
    assign conv_data = m_raw;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_done <= 1'b0; m_idx <= '0; m_lat <= '0; m_raw <= '0;
        end else if (conv_done_clr) begin
            m_done <= 1'b0; m_idx <= m_idx + 1'b1; m_lat <= '0;
        end else if (conv_start && !m_done) begin
            if (m_lat >= 4'(m_idx[1:0]) + 4'd1) begin
                m_done <= 1'b1;
                m_raw  <= {garb[m_idx[4:0]], smp[m_idx[4:0]]};
            end else begin
                m_lat <= m_lat + 1'b1;
            end
        end
    end

    // port monitor
    int   n_starts = 0, n_clears = 0, bad_init = 0, bad_cfg = 0, bad_hs = 0;
    logic init_ok = 1'b0, prev_start = 1'b0;
    logic [2:0] exp_atten = '0;
    logic       exp_src = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (init_code_wr) init_ok = (init_code_hi == 8'd0) && (init_code_lo == 8'd0);
            if (conv_start && !prev_start) begin
                n_starts++;
                if (!init_ok) bad_init++;
                init_ok = 1'b0;
                if (conv_chan != 4'd15 || conv_atten != exp_atten || !conv_ref_en ||
                    !conv_oneshot_en || cal_gnd_conn != !exp_src || cal_ref_conn != exp_src)
                    bad_cfg++;
            end
            if (conv_done_clr) begin
                n_clears++;
                if (!conv_start) bad_hs++;
            end
            if (prev_start && !conv_start && n_clears == 0) bad_hs++;
            prev_start = conv_start;
        end
    end

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] gen(input int p, input int i);
        int v;
        case (p)
            0: v = 0;
            1: v = 4095;
            2: v = i * 128 + 5;
            3: v = (i == 7) ? 4095 : (i == 20) ? 0 : 1000;
            4: v = (i == 3 || i == 9) ? 4095 : (i == 11 || i == 30) ? 17 : 2000;
            default: v = (i * 2654435 + p * 40503 + (i * i * 7)) % 4096;
        endcase
        return 12'(v);
    endfunction

    task automatic run_cal(input int p);
        int sum = 0, mx = 0, mn = 4095, expv, s0, c0, b0, b1, b2, to, spur_n;
        for (int i = 0; i < NS; i++) begin
            smp[i]  = gen(p, i);
            garb[i] = 4'((i * 3 + p) | 1);
            sum += int'(smp[i]);
            if (int'(smp[i]) > mx) mx = int'(smp[i]);
            if (int'(smp[i]) < mn) mn = int'(smp[i]);
        end
        expv = (sum - mx - mn) / 30;
        exp_atten = 3'(p % 8);
        exp_src   = 1'(p % 2);
        s0 = n_starts; c0 = n_clears; b0 = bad_init; b1 = bad_cfg; b2 = bad_hs;
        @(negedge clk);
        req_start = 1'b1; req_atten = exp_atten; req_src = exp_src;
        @(negedge clk);
        req_start = 1'b0; req_atten = ~exp_atten; req_src = ~exp_src;
        check(busy == 1'b1, "R2 busy after request", int'(busy), 1);
        to = 0; spur_n = 0;
        while (!result_valid && to < 5000) begin
            @(negedge clk);
            to++;
            req_start = (p == 5 && to == 10);
            if (p == 6 && n_clears - c0 == NS && spur_n < 3) begin
                spur = 1'b1; spur_n++;
            end else spur = 1'b0;
        end
        spur = 1'b0; req_start = 1'b0;
        check(result_valid == 1'b1, "R8 valid seen", int'(result_valid), 1);
        check(result == 12'(expv), "R7/R6 result", int'(result), expv);
        check(n_starts - s0 == NS, "R4 conversion count", n_starts - s0, NS);
        check(bad_init == b0, "R5 zero init code before start", bad_init - b0, 0);
        check(bad_hs == b2 && n_clears - c0 == NS, "R5 clear handshake", n_clears - c0, NS);
        check(bad_cfg == b1, "R2/R3 channel, attenuation, source", bad_cfg - b1, 0);
        check(!cal_gnd_conn && !cal_ref_conn && busy, "R8 disconnected, busy at valid",
              int'({cal_gnd_conn, cal_ref_conn, busy}), 1);
        @(negedge clk);
        check(!result_valid && !busy, "R8 valid pulse, busy falls",
              int'({result_valid, busy}), 0);
        repeat (4) @(negedge clk);
        check(!busy, (p == 5) ? "R9 no restart after ignored request" : "R9 idle after run",
              int'(busy), 0);
        if (p == 6)
            check(n_starts - s0 == NS, "R10 late done ignored", n_starts - s0, NS);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({busy, result_valid, conv_start, conv_done_clr, init_code_wr, conv_ref_en,
               conv_oneshot_en, cal_gnd_conn, cal_ref_conn} == '0, "R1 reset outputs",
              int'({busy, result_valid, conv_start, conv_done_clr, init_code_wr,
                    conv_ref_en, conv_oneshot_en, cal_gnd_conn, cal_ref_conn}), 0);
        for (int p = 0; p < 12; p++) begin
            if (p == 7) begin
                // R10: stray done while idle
                spur = 1'b1;
                repeat (4) @(negedge clk);
                spur = 1'b0;
                check(!busy && !conv_start, "R10 idle done ignored",
                      int'({busy, conv_start}), 0);
            end
            run_cal(p);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule